// File: doc/BRIEF.md
# Burst Address Counter

This block is the address front end of one port of a synchronous memory. At each rising clock edge it updates a registered internal address. It can take an address from the external bus, keep its present value, move to the next consecutive address for a burst, or go to zero. The registered value drives the memory array directly.

Four active-low controls choose the action. A port select qualifies the port. An address strobe captures the external address. A step enable advances the counter. A counter clear forces zero. The clear takes priority over every other control. When the port is selected, the strobe takes priority over stepping. Stepping runs across the whole address space and rolls over from the top address to zero. An active-low synchronous reset also brings the address to zero. All controls are sampled on the rising edge, and the new address is visible on the output after that edge.

Top module: `burst_addr_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, `addr_out` becomes zero after that edge.
- R2: While `clear_n` is low at a rising edge, `addr_out` becomes zero after that edge, whatever the values of `sel_n`, `strobe_n` and `step_n`.
- R3: With `clear_n` high, `sel_n` low and `strobe_n` low at a rising edge, `addr_out` takes the value of `addr_in` sampled at that edge.
- R4: With `clear_n` high, `sel_n` low, `strobe_n` high and `step_n` low at a rising edge, `addr_out` increases by one.
- R5: `step_n` has no effect in a cycle where `strobe_n` or `clear_n` is low: the load (R3) or the clear (R2) takes place instead.
- R6: A step from the all-ones address (2^AW-1, with AW = 16 by default) gives zero.
- R7: With `clear_n`, `strobe_n` and `step_n` all high, `addr_out` keeps its value.
- R8: With `sel_n` high and `clear_n` high, `strobe_n` and `step_n` are ignored and `addr_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low port select; gates load and step |
| strobe_n | input | 1 | Active-low address strobe; loads `addr_in` |
| step_n | input | 1 | Active-low step enable; advances by one |
| clear_n | input | 1 | Active-low counter clear; highest priority |
| addr_in | input | AW | External address bus |
| addr_out | output | AW | Registered internal address |

## Verification
The assertions assume that every control and the address bus hold settled, known values at each rising edge. They also assume that reset is held low for at least one edge before normal use, so that the previous cycle's address is defined. The bench changes all inputs on the falling edge only and starts with two reset edges. It then applies combinations of the controls that set the priorities against each other. These include the strobe together with stepping, the clear together with both of them, and a deselected port with the strobe or the step active.

// File: rtl/bac_pkg.sv
// Shared types for the burst address counter.
// Assumes: nothing beyond a 2-bit encoding of the per-edge action.
package bac_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2,
        OP_STEP  = 2'd3
    } op_e;
endpackage

// File: rtl/bac_ctrl_decode.sv
// Turns the four active-low controls into one action per edge.
// Priority: clear, then port select, then strobe, then step, then hold.
// Assumes: inputs are already synchronous to the counter's clock.
module bac_ctrl_decode
    import bac_pkg::*;
(
    input  logic sel_n,
    input  logic strobe_n,
    input  logic step_n,
    input  logic clear_n,
    output op_e  op
);
    // Resolve the fixed priority among the controls.
    always_comb begin
        if (!clear_n)       op = OP_CLEAR;
        else if (sel_n)     op = OP_HOLD;
        else if (!strobe_n) op = OP_LOAD;
        else if (!step_n)   op = OP_STEP;
        else                op = OP_HOLD;
    end
endmodule

// File: rtl/bac_addr_reg.sv
// Address register: applies the decoded action at each rising edge.
// A step from the top address rolls over to zero.
// Assumes: op is stable at the edge; rst_n is a synchronous active-low reset.
module bac_addr_reg
    import bac_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_q
);
    localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

    logic [AW-1:0] step_val;

    // Next address for a step, with explicit rollover at the top.
    always_comb begin
        if (addr_q == TOP_ADDR) step_val = '0;
        else                    step_val = addr_q + 1'b1;
    end

    // Register update for the selected action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            case (op)
                OP_CLEAR: addr_q <= '0;
                OP_LOAD:  addr_q <= addr_in;
                OP_STEP:  addr_q <= step_val;
                default:  addr_q <= addr_q;
            endcase
        end
    end
endmodule

// File: rtl/burst_addr_counter.sv
// Per-port burst address counter: load, hold, step or clear a registered
// address each rising edge. The output drives the memory array directly.
// Assumes: all inputs synchronous to clk; reset held for at least one edge.
module burst_addr_counter
    import bac_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          strobe_n,
    input  logic          step_n,
    input  logic          clear_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_out
);
    op_e op;

    bac_ctrl_decode u_dec (
        .sel_n    (sel_n),
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .clear_n  (clear_n),
        .op       (op)
    );

    bac_addr_reg #(.AW(AW)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .addr_in (addr_in),
        .addr_q  (addr_out)
    );

    // Port-level checks of the priority and update rules.
    logic [AW-1:0] plus_one;
    assign plus_one = addr_out + 1'b1;

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> addr_out == '0);

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> addr_out == '0);

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !sel_n && !strobe_n) |=> addr_out == $past(addr_in));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !sel_n && strobe_n && !step_n) |=> addr_out == $past(plus_one));

    a_r6_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && !sel_n && strobe_n && !step_n && (&addr_out)) |=> addr_out == '0);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && strobe_n && step_n) |=> $stable(addr_out));

    a_r8_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_n && sel_n) |=> $stable(addr_out));
endmodule

// File: tb/burst_addr_counter_test.sv
module burst_addr_counter_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_counter #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strobe_n(strobe_n),
        .step_n(step_n), .clear_n(clear_n), .addr_in(addr_in), .addr_out(addr_out)
    );

    // One edge: drive on the falling edge, sample just after the rising edge.
    task automatic cyc(input logic s, input logic st, input logic sp,
                       input logic cl, input logic [AW-1:0] a);
        @(negedge clk);
        sel_n = s; strobe_n = st; step_n = sp; clear_n = cl; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [AW-1:0] exp);
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R1", '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_load();
        cyc(0, 0, 1, 1, 16'h1234); check("R3", 16'h1234);
        cyc(0, 0, 1, 1, 16'hBEEF); check("R3", 16'hBEEF);
    endtask

    task automatic t_step();
        cyc(0, 1, 0, 1, 16'h0000); check("R4", 16'hBEF0);
        cyc(0, 1, 0, 1, 16'h0000); check("R4", 16'hBEF1);
        cyc(0, 1, 0, 1, 16'h0000); check("R4", 16'hBEF2);
    endtask

    task automatic t_hold();
        cyc(0, 1, 1, 1, 16'h7777); check("R7", 16'hBEF2);
        cyc(0, 1, 1, 1, 16'h0001); check("R7", 16'hBEF2);
    endtask

    task automatic t_priority();
        cyc(0, 0, 0, 1, 16'h0100); check("R5 strobe over step", 16'h0100);
        cyc(0, 1, 0, 0, 16'h0000); check("R5 clear over step", 16'h0000);
        cyc(0, 0, 1, 1, 16'h4242); check("R3", 16'h4242);
        cyc(1, 0, 0, 0, 16'h9999); check("R2 clear while deselected", 16'h0000);
        cyc(0, 0, 1, 1, 16'h3000); check("R3", 16'h3000);
        cyc(0, 0, 0, 0, 16'h8888); check("R2 clear over strobe", 16'h0000);
    endtask

    task automatic t_wrap();
        cyc(0, 0, 1, 1, 16'hFFFE); check("R3", 16'hFFFE);
        cyc(0, 1, 0, 1, 16'h0000); check("R6", 16'hFFFF);
        cyc(0, 1, 0, 1, 16'h0000); check("R6 rollover", 16'h0000);
        cyc(0, 1, 0, 1, 16'h0000); check("R6", 16'h0001);
    endtask

    task automatic t_deselect();
        cyc(0, 0, 1, 1, 16'h5555); check("R3", 16'h5555);
        cyc(1, 0, 1, 1, 16'hAAAA); check("R8 strobe ignored", 16'h5555);
        cyc(1, 1, 0, 1, 16'h0000); check("R8 step ignored", 16'h5555);
        cyc(1, 0, 0, 1, 16'h1111); check("R8 both ignored", 16'h5555);
    endtask

    task automatic t_midreset();
        cyc(0, 0, 1, 1, 16'hC0DE); check("R3", 16'hC0DE);
        @(negedge clk); rst_n = 1'b0; sel_n = 1'b0; strobe_n = 1'b0; addr_in = 16'h1357;
        @(posedge clk); #1;
        check("R1 reset over load", 16'h0000);
        @(negedge clk); rst_n = 1'b1; strobe_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: addr_out=%h expected=done", addr_out);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load();
        t_step();
        t_hold();
        t_priority();
        t_wrap();
        t_deselect();
        t_midreset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule